// File: doc/BRIEF.md
# Backtracking Circuit-Switched Mesh Router

This block is a single router tile for a two-dimensional circuit-switched on-chip mesh. It has five ports: one toward the attached core and four toward neighbouring tiles. A source reserves an end-to-end circuit by sending a probe flit that carries the destination coordinates. Each router on the way picks an output for the probe. If that output is already held, or is lost in arbitration, the router does not wait. It moves straight on to the next candidate. When a downstream tile refuses the probe, it sends a refusal pulse back. The router then frees the output it had reserved and tries another. Once it has run out of candidates, it sends the refusal one hop further back.

When the destination core accepts, a confirmation pulse travels back hop by hop and the circuit is live. Payload flits then stream through the crossbar with valid/ready flow control. The crossbar has one register stage per hop. A teardown flit follows the same route, and each output is released as the teardown leaves it. Each router is parameterised with its own coordinates and the mesh size. The default mesh is 8x8, and tile numbers run row by row as y*8+x.

Top module: `mesh_cs_router`

## Requirements
- R1: During and right after reset, every out_vld, in_ack and in_nack bit is low and every in_rdy bit is high.
- R2: Port index 0 is the core, 1 is north (y-1), 2 is east (x+1), 3 is south (y+1) and 4 is west (x-1). Flit kinds are 2'b01 probe, 2'b10 payload and 2'b11 teardown. A probe's data carries the destination x in bits [3:0] and the destination y in bits [7:4], and the router forwards it unchanged.
- R3: Candidate outputs are tried in a fixed order. If the destination is this tile, the only candidate is the core port. Otherwise the order is the x-direction port (if x differs), then the y-direction port (if y differs), then the remaining neighbour ports in the order north, east, south, west. The port the probe arrived on, ports that would leave the mesh, and the core port (unless the destination is this tile) are never candidates.
- R4: A candidate output already held by another circuit is skipped without any flit appearing on it.
- R5: A refusal pulse on out_nack of the output currently holding a probe releases that output, and the next candidate is tried. When no candidate is left, a single-cycle in_nack pulse is raised on the arrival port, and in_rdy on that port then goes high.
- R6: A confirmation pulse on out_ack of the output holding a probe produces a single-cycle in_ack pulse on the arrival port. That input then enters the connected state.
- R7: In the connected state, a payload flit accepted on the input appears on the reserved output in the next cycle, and flits keep their order. While out_rdy is low, the output flit holds steady and the input stops accepting once the stage is full.
- R8: A teardown flit passes along the circuit. The output is freed once the teardown leaves it, and a later probe can reserve that output again.
- R9: Each output has round-robin arbitration with a one-cycle grant latency. When two probes want the same free output in the same cycle, one gets it, the other treats it as busy, and the winner alternates between rounds with the same two contenders.
- R10: Payload or teardown flits arriving on an idle input are taken and dropped. They produce no output flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 5 | Flit valid, one bit per input port |
| in_kind | input | 10 | Flit kind, 2 bits per input port |
| in_data | input | 40 | Flit data, 8 bits per input port |
| in_rdy | output | 5 | Input ready per port |
| in_ack | output | 5 | Circuit confirmation pulse sent back upstream |
| in_nack | output | 5 | Refusal pulse sent back upstream |
| out_vld | output | 5 | Flit valid per output port |
| out_kind | output | 10 | Flit kind, 2 bits per output port |
| out_data | output | 40 | Flit data, 8 bits per output port |
| out_rdy | input | 5 | Downstream ready per output port |
| out_ack | input | 5 | Confirmation pulse from downstream |
| out_nack | input | 5 | Refusal pulse from downstream |

## Verification
The bench places the router at the top edge of the mesh, so ports that would leave the mesh have to be excluded. From every arrival port it sends a probe to every tile. It refuses each probe in turn and checks the complete candidate order and the final refusal upstream. A design that sent a probe back the way it came, or tried a non-minimal port before a productive one, would emit a flit on the wrong port. The bench also holds the east output with a live circuit and sends a probe to tile 12. This checks the detour through the south port: a router that stalled, or leaked the probe onto the held link, would break that check. Finally, the bench covers payload timing and backpressure, release of the output by teardown, round-robin alternation under contention, and the dropping of stray payload on an idle input.

// File: rtl/mesh_cs_router.sv
module mesh_cs_router #(
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int MY_X   = 3,
  parameter int MY_Y   = 0,
  parameter int DW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      in_vld,
  input  logic [9:0]      in_kind,
  input  logic [5*DW-1:0] in_data,
  output logic [4:0]      in_rdy,
  output logic [4:0]      in_ack,
  output logic [4:0]      in_nack,
  output logic [4:0]      out_vld,
  output logic [9:0]      out_kind,
  output logic [5*DW-1:0] out_data,
  input  logic [4:0]      out_rdy,
  input  logic [4:0]      out_ack,
  input  logic [4:0]      out_nack
);
  localparam int NP = 5;
  localparam int PW = 3;
  localparam int CW = DW / 2;
  localparam logic [1:0] K_PROBE = 2'd1;
  localparam logic [1:0] K_TEAR  = 2'd3;
  localparam logic [PW-1:0] P_L = 3'd0, P_N = 3'd1, P_E = 3'd2, P_S = 3'd3, P_W = 3'd4;
  localparam logic [NP-1:0] EXIST = {MY_X > 0, MY_Y < MESH_Y - 1, MY_X < MESH_X - 1, MY_Y > 0, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_REQ, S_GNT, S_SEND, S_RESP, S_CONN} st_t;

  st_t           st    [NP];
  logic [PW-1:0] outp  [NP];
  logic [NP-1:0] tried [NP];
  logic [DW-1:0] dst   [NP];
  logic [PW:0]   cand  [NP];

  logic [NP-1:0] res;
  logic [PW-1:0] own   [NP];
  logic [PW-1:0] rr    [NP];
  logic [NP-1:0] gnt;
  logic [NP-1:0] req_m [NP];
  logic [NP-1:0] win_v;
  logic [PW-1:0] win   [NP];

  logic [NP-1:0] ov;
  logic [1:0]    okind [NP];
  logic [DW-1:0] odat  [NP];
  logic [NP-1:0] canld, ld, rel, drn, is_gnt;
  logic [1:0]    fk    [NP];
  logic [DW-1:0] fd    [NP];

  function automatic logic [PW:0] pick(input logic [DW-1:0] d, input logic [PW-1:0] a,
                                       input logic [NP-1:0] t);
    int dx, dy;
    logic [NP-1:0] ok_m;
    logic [PW-1:0] px, py;
    dx = int'(d[CW-1:0]);
    dy = int'(d[DW-1:CW]);
    ok_m = EXIST & ~t;
    ok_m[a] = 1'b0;
    pick = '0;
    if (dx == MY_X && dy == MY_Y) begin
      if (ok_m[P_L]) pick = {1'b1, P_L};
    end else begin
      ok_m[P_L] = 1'b0;
      px = (dx > MY_X) ? P_E : P_W;
      py = (dy > MY_Y) ? P_S : P_N;
      for (int k = NP - 1; k >= 1; k--)
        if (ok_m[k]) pick = {1'b1, PW'(k)};
      if (dy != MY_Y && ok_m[py]) pick = {1'b1, py};
      if (dx != MY_X && ok_m[px]) pick = {1'b1, px};
    end
  endfunction

  always_comb
    for (int i = 0; i < NP; i++) cand[i] = pick(dst[i], PW'(i), tried[i]);

  always_comb begin
    for (int o = 0; o < NP; o++) req_m[o] = '0;
    for (int i = 0; i < NP; i++)
      if (st[i] == S_REQ) req_m[outp[i]][i] = 1'b1;
  end

  always_comb
    for (int o = 0; o < NP; o++) begin
      win_v[o] = 1'b0;
      win[o]   = '0;
      for (int k = NP - 1; k >= 0; k--) begin
        int j;
        j = int'(rr[o]) + k;
        if (j >= NP) j = j - NP;
        if (req_m[o][j]) begin
          win_v[o] = 1'b1;
          win[o]   = PW'(j);
        end
      end
    end

  always_comb begin
    rel = '0;
    for (int i = 0; i < NP; i++)
      if (st[i] == S_RESP && out_nack[outp[i]]) rel[outp[i]] = 1'b1;
  end

  assign canld = ~ov | out_rdy;

  always_comb
    for (int o = 0; o < NP; o++) begin
      drn[o] = ov[o] && out_rdy[o] && okind[o] == K_TEAR;
      fk[o]  = (st[own[o]] == S_SEND) ? K_PROBE : in_kind[own[o]*2 +: 2];
      fd[o]  = (st[own[o]] == S_SEND) ? dst[own[o]] : in_data[own[o]*DW +: DW];
      ld[o]  = res[o] && canld[o] &&
               (st[own[o]] == S_SEND || (st[own[o]] == S_CONN && in_vld[own[o]]));
    end

  always_comb
    for (int i = 0; i < NP; i++) begin
      in_rdy[i]  = st[i] == S_IDLE || (st[i] == S_CONN && canld[outp[i]]);
      in_ack[i]  = st[i] == S_RESP && out_ack[outp[i]];
      in_nack[i] = st[i] == S_PICK && !cand[i][PW];
      is_gnt[i]  = st[i] == S_GNT;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        st[i]    <= S_IDLE;
        outp[i]  <= '0;
        tried[i] <= '0;
        dst[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NP; i++)
        case (st[i])
          S_IDLE:
            if (in_vld[i] && in_kind[i*2 +: 2] == K_PROBE) begin
              st[i]    <= S_PICK;
              dst[i]   <= in_data[i*DW +: DW];
              tried[i] <= '0;
            end
          S_PICK:
            if (!cand[i][PW]) st[i] <= S_IDLE;
            else if (res[cand[i][PW-1:0]]) tried[i][cand[i][PW-1:0]] <= 1'b1;
            else begin
              outp[i] <= cand[i][PW-1:0];
              st[i]   <= S_REQ;
            end
          S_REQ: st[i] <= S_GNT;
          S_GNT:
            if (gnt[i]) st[i] <= S_SEND;
            else begin
              tried[i][outp[i]] <= 1'b1;
              st[i]             <= S_PICK;
            end
          S_SEND: if (ld[outp[i]]) st[i] <= S_RESP;
          S_RESP:
            if (out_ack[outp[i]]) st[i] <= S_CONN;
            else if (out_nack[outp[i]]) begin
              tried[i][outp[i]] <= 1'b1;
              st[i]             <= S_PICK;
            end
          S_CONN:
            if (in_vld[i] && canld[outp[i]] && in_kind[i*2 +: 2] == K_TEAR) st[i] <= S_IDLE;
          default: st[i] <= S_IDLE;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res <= '0;
      gnt <= '0;
      for (int o = 0; o < NP; o++) begin
        own[o] <= '0;
        rr[o]  <= '0;
      end
    end else begin
      gnt <= '0;
      for (int o = 0; o < NP; o++) begin
        if (rel[o] || drn[o]) res[o] <= 1'b0;
        if (!res[o] && win_v[o]) begin
          res[o]      <= 1'b1;
          own[o]      <= win[o];
          rr[o]       <= (win[o] == PW'(NP - 1)) ? '0 : win[o] + 1'b1;
          gnt[win[o]] <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ov <= '0;
      for (int o = 0; o < NP; o++) begin
        okind[o] <= '0;
        odat[o]  <= '0;
      end
    end else begin
      for (int o = 0; o < NP; o++)
        if (ld[o]) begin
          ov[o]    <= 1'b1;
          okind[o] <= fk[o];
          odat[o]  <= fd[o];
        end else if (out_rdy[o]) ov[o] <= 1'b0;
    end

  assign out_vld = ov;
  always_comb
    for (int o = 0; o < NP; o++) begin
      out_kind[o*2 +: 2]  = okind[o];
      out_data[o*DW +: DW] = odat[o];
    end

endmodule

// File: rtl/mesh_cs_router_chk.sv
module mesh_cs_router_chk #(
  parameter int NP = 5,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NP-1:0]   in_rdy,
  input logic [NP-1:0]   in_ack,
  input logic [NP-1:0]   in_nack,
  input logic [NP-1:0]   out_vld,
  input logic [2*NP-1:0] out_kind,
  input logic [NP*DW-1:0] out_data,
  input logic [NP-1:0]   out_rdy,
  input logic [NP-1:0]   res,
  input logic [NP-1:0]   gnt,
  input logic [NP-1:0]   is_gnt
);
  for (genvar p = 0; p < NP; p++) begin : g_p
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[p] && !out_rdy[p] |=> out_vld[p] && $stable(out_data[p*DW +: DW]) && $stable(out_kind[p*2 +: 2])); // R7
    AST_VLD_ON_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[p] |-> res[p]); // R8
    AST_ACK_NACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ack[p] && in_nack[p])); // R5
    AST_NACK_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      in_nack[p] |=> in_rdy[p]); // R5
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      in_ack[p] |=> !in_ack[p]); // R6
    AST_GNT_MATCHES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[p] |-> is_gnt[p]); // R9
  end
endmodule

bind mesh_cs_router mesh_cs_router_chk #(.NP(5), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .in_ack(in_ack), .in_nack(in_nack),
  .out_vld(out_vld), .out_kind(out_kind), .out_data(out_data), .out_rdy(out_rdy),
  .res(res), .gnt(gnt), .is_gnt(is_gnt)
);

// File: tb/mesh_cs_router_tb.sv
module mesh_cs_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MX = 3, MY = 0;
  localparam logic [1:0] KP = 2'd1, KD = 2'd2, KT = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] in_vld = '0, out_rdy = '1, out_ack = '0, out_nack = '0;
  logic [9:0] in_kind = '0;
  logic [39:0] in_data = '0;
  logic [4:0] in_rdy, in_ack, in_nack, out_vld;
  logic [9:0] out_kind;
  logic [39:0] out_data;

  int checks = 0, fails = 0;
  int nflits = 0, lastp = -1, lastk = 0, lastd = 0;
  int cnt[5], ack_cnt[5], nack_cnt[5], lastd_p[5];
  int seqd[64];
  int seqn = 0;
  int el[4];
  int en;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesh_cs_router #(.MESH_X(8), .MESH_Y(8), .MY_X(MX), .MY_Y(MY), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_kind(in_kind), .in_data(in_data),
    .in_rdy(in_rdy), .in_ack(in_ack), .in_nack(in_nack), .out_vld(out_vld),
    .out_kind(out_kind), .out_data(out_data), .out_rdy(out_rdy), .out_ack(out_ack),
    .out_nack(out_nack));

  initial for (int p = 0; p < 5; p++) begin cnt[p] = 0; ack_cnt[p] = 0; nack_cnt[p] = 0; lastd_p[p] = 0; end

  always @(negedge clk) if (rst_n) begin
    for (int p = 0; p < 5; p++) begin
      if (out_vld[p] && out_rdy[p]) begin
        nflits++; cnt[p]++; lastp = p;
        lastk = int'(out_kind[p*2 +: 2]); lastd = int'(out_data[p*8 +: 8]); lastd_p[p] = lastd;
        if (p == 2 && out_kind[5:4] == KD && seqn < 64) begin seqd[seqn] = lastd; seqn++; end
      end
      if (in_ack[p]) ack_cnt[p]++;
      if (in_nack[p]) nack_cnt[p]++;
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", rq, act, exp); end
  endtask

  task automatic put(input int p, input logic [1:0] k, input logic [7:0] d);
    in_vld[p] = 1'b1; in_kind[p*2 +: 2] = k; in_data[p*8 +: 8] = d;
  endtask

  task automatic wait_flits(input int target);
    for (int k = 0; k < 40 && nflits < target; k++) step();
  endtask

  task automatic exists_add(input int p, input int a);
    bit ex, dup;
    ex = (p == 1) ? MY > 0 : (p == 2) ? MX < 7 : (p == 3) ? MY < 7 : MX > 0;
    dup = 1'b0;
    for (int k = 0; k < en; k++) if (el[k] == p) dup = 1'b1;
    if (ex && !dup && p != a) begin el[en] = p; en++; end
  endtask

  task automatic build_list(input int a, input int x, input int y);
    en = 0;
    if (x == MX && y == MY) begin
      if (a != 0) begin el[0] = 0; en = 1; end
    end else begin
      if (x != MX) exists_add((x > MX) ? 2 : 4, a);
      if (y != MY) exists_add((y > MY) ? 3 : 1, a);
      for (int p = 1; p < 5; p++) exists_add(p, a);
    end
  endtask

  task automatic open_ckt(input int a, input logic [7:0] d, input int e, input string rq);
    int b, ab;
    b = nflits; ab = ack_cnt[a];
    put(a, KP, d); step(); in_vld[a] = 1'b0;
    wait_flits(b + 1);
    chk(lastp == e && lastk == KP, rq, lastp, e);
    out_ack[e] = 1'b1; step(); out_ack[e] = 1'b0;
    chk(ack_cnt[a] == ab + 1, "R6 ack upstream", ack_cnt[a], ab + 1);
  endtask

  task automatic close_ckt(input int a);
    put(a, KT, 8'h00); step(); in_vld[a] = 1'b0;
    repeat (3) step();
  endtask

  int w1;

  initial begin
    repeat (2) @(negedge clk);
    chk(out_vld == 5'h00 && in_ack == 5'h00 && in_nack == 5'h00, "R1 reset outputs", int'(out_vld), 0);
    chk(in_rdy == 5'h1f, "R1 reset ready", int'(in_rdy), 31);
    step(); rst_n = 1'b1; step();
    chk(out_vld == 5'h00 && in_rdy == 5'h1f, "R1 after reset", int'(out_vld), 0);

    begin : r10_drop
      int b;
      b = nflits;
      put(2, KD, 8'h55); step(); put(2, KT, 8'h00); step(); in_vld[2] = 1'b0;
      repeat (5) step();
      chk(nflits == b, "R10 idle drop", nflits, b);
      chk(in_rdy == 5'h1f, "R10 still idle", int'(in_rdy), 31);
    end

    for (int a = 0; a < 5; a++)
      for (int y = 0; y < 8; y++)
        for (int x = 0; x < 8; x++) begin
          int b, nb;
          logic [7:0] d;
          d = {y[3:0], x[3:0]};
          build_list(a, x, y);
          b = nflits; nb = nack_cnt[a];
          put(a, KP, d); step(); in_vld[a] = 1'b0;
          for (int k = 0; k < en; k++) begin
            wait_flits(b + k + 1);
            chk(lastp == el[k], "R3 candidate order", lastp, el[k]);
            chk(lastk == KP && lastd == int'(d), "R2 probe forwarded", lastd, int'(d));
            out_nack[el[k]] = 1'b1; step(); out_nack[el[k]] = 1'b0;
          end
          for (int k = 0; k < 20 && nack_cnt[a] == nb; k++) step();
          chk(nack_cnt[a] == nb + 1, "R5 refusal upstream", nack_cnt[a], nb + 1);
          chk(nflits == b + en, "R5 no extra probe", nflits, b + en);
          chk(in_rdy[a] == 1'b1, "R5 ready after refusal", int'(in_rdy[a]), 1);
        end

    open_ckt(4, 8'h04, 2, "R3 open west to east");
    put(4, KD, 8'hA5);
    @(negedge clk);
    chk(out_vld[2] == 1'b0, "R7 not before stage", int'(out_vld[2]), 0);
    step(); in_vld[4] = 1'b0;
    @(negedge clk);
    chk(out_vld[2] == 1'b1 && out_data[23:16] == 8'hA5, "R7 one stage latency", int'(out_data[23:16]), 165);
    step();
    seqn = 0;
    for (int k = 0; k < 6; k++) begin put(4, KD, 8'(k * 17 + 3)); step(); end
    in_vld[4] = 1'b0;
    repeat (3) step();
    chk(seqn == 6, "R7 stream count", seqn, 6);
    for (int k = 0; k < 6; k++) chk(seqd[k] == k * 17 + 3, "R7 stream order", seqd[k], k * 17 + 3);

    out_rdy[2] = 1'b0;
    put(4, KD, 8'h3C); step(); put(4, KD, 8'h3D);
    @(negedge clk);
    chk(in_rdy[4] == 1'b0, "R7 backpressure", int'(in_rdy[4]), 0);
    step(); step();
    @(negedge clk);
    chk(out_vld[2] == 1'b1 && out_data[23:16] == 8'h3C, "R7 held under stall", int'(out_data[23:16]), 60);
    out_rdy[2] = 1'b1;
    step(); in_vld[4] = 1'b0;
    @(negedge clk);
    chk(out_data[23:16] == 8'h3D, "R7 after stall", int'(out_data[23:16]), 61);
    step();

    begin : r8_tear
      int b;
      b = nflits;
      put(4, KT, 8'h00); step(); in_vld[4] = 1'b0;
      wait_flits(b + 1);
      chk(lastp == 2 && lastk == KT, "R8 teardown forwarded", lastk, 3);
      repeat (2) step();
      open_ckt(0, 8'h04, 2, "R8 east free again");
      close_ckt(0);
    end

    begin : r4_busy
      int b, ce, nb;
      open_ckt(4, 8'h04, 2, "R4 hold east");
      b = nflits; ce = cnt[2]; nb = nack_cnt[0];
      put(0, KP, 8'h14); step(); in_vld[0] = 1'b0;
      wait_flits(b + 1);
      chk(lastp == 3, "R4 detour to south", lastp, 3);
      chk(cnt[2] == ce, "R4 nothing on held link", cnt[2], ce);
      out_nack[3] = 1'b1; step(); out_nack[3] = 1'b0;
      wait_flits(b + 2);
      chk(lastp == 4, "R4 then west", lastp, 4);
      out_nack[4] = 1'b1; step(); out_nack[4] = 1'b0;
      for (int k = 0; k < 20 && nack_cnt[0] == nb; k++) step();
      chk(nack_cnt[0] == nb + 1, "R5 exhausted with east held", nack_cnt[0], nb + 1);
      close_ckt(4);
    end

    w1 = -1;
    for (int r = 0; r < 2; r++) begin
      int ce, cs, w;
      ce = cnt[2]; cs = cnt[3];
      put(0, KP, 8'h04); put(1, KP, 8'h14); step(); in_vld[0] = 1'b0; in_vld[1] = 1'b0;
      repeat (15) step();
      chk(cnt[2] == ce + 1 && cnt[3] == cs + 1, "R9 one wins one detours", cnt[3], cs + 1);
      w = (lastd_p[2] == 8'h04) ? 0 : 1;
      chk(lastd_p[3] == ((w == 0) ? 8'h14 : 8'h04), "R9 loser on south", lastd_p[3], (w == 0) ? 20 : 4);
      if (r == 1) chk(w != w1, "R9 round robin alternates", w, 1 - w1);
      w1 = w;
      out_ack[2] = 1'b1; out_ack[3] = 1'b1; step(); out_ack[2] = 1'b0; out_ack[3] = 1'b0;
      put(0, KT, 8'h00); put(1, KT, 8'h00); step(); in_vld[0] = 1'b0; in_vld[1] = 1'b0;
      repeat (4) step();
      chk(in_rdy[0] == 1'b1 && in_rdy[1] == 1'b1, "R8 both closed", int'(in_rdy[1:0]), 3);
    end

    report();
  end
endmodule